// File: doc/BRIEF.md
# Streaming Rank-Counter Median Selector

This block finds the median of a window of N samples that arrive one per cycle on a valid/last stream. It keeps every sample of the current window in a register file, together with a small rank counter for each one. Each arriving sample is compared in parallel against all samples already held. Every held sample that is strictly greater than the newcomer has its rank raised by one. The newcomer starts from its arrival position and loses one for each such sample. Once the window is complete, the ranks form a permutation of 0..N-1. The median is the sample whose rank equals (N-1)/2.

The result gives both the median value and the position of that sample within the window. A caller can use the position to fetch data that travelled with the sample, for example the full colour triple when the median was taken on luminance. Windows are formed upstream. The block only sees a flat stream in which the N-th sample of each window carries the last flag.

Top module: `median_rank_select`

## Requirements
- R1: While reset is held and after it is released, out_valid, out_median and out_index are all zero until the first result.
- R2: A sample arriving at position p (counting from 0) starts with rank p. Every held sample strictly greater than it gains one rank and the new sample loses one. The reported median is the sample whose final rank is (N-1)/2.
- R3: Equal samples receive distinct ranks, and the later one ranks above the earlier one. A rank is therefore the count of strictly smaller samples plus the count of equal samples that arrived earlier.
- R4: out_index is the arrival position (0 to N-1) of the selected sample within its window, and out_median equals that sample's value.
- R5: out_valid is high exactly in the cycle after a cycle with in_valid and in_last both high, and low otherwise.
- R6: out_median and out_index keep their values until the next result is produced.
- R7: A cycle with in_valid low changes nothing, whatever in_data and in_last carry.
- R8: Samples that arrive after the N-th sample of a window but before the last flag are dropped. The result is taken from the first N samples.
- R9: After a result, the next sample starts a new window at position 0. Nothing from the previous window affects the new result.
- R10: For N=5, the window 20, 42, 31, 16, 75 yields median 31 at index 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present on in_data |
| in_last | input | 1 | Sample closes the current window (qualified by in_valid) |
| in_data | input | DW | Sample value, unsigned |
| out_valid | output | 1 | One-cycle strobe, result ready |
| out_median | output | DW | Median value of the last window |
| out_index | output | $clog2(N) | Arrival position of the median within its window |

## Verification
The hardest case to reach is the tie handling. Several equal samples must compete for the middle rank, and only their arrival order decides which position is reported. Random wide-range data almost never produces that. The bench therefore sweeps every window of five samples drawn from the values 0 to 4 (3125 windows back to back). This covers every pattern of duplicates and every order. Separate windows insert idle cycles that carry a stray last flag, and overlong windows check that extra samples are dropped.

// File: rtl/median_rank_select.sv
module median_rank_select #(
  parameter int N  = 5,
  parameter int DW = 8,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int PW  = $clog2(N + 1),
  localparam int MID = (N - 1) / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_median,
  output logic [IW-1:0] out_index
);

  logic [DW-1:0] smp_q  [N];
  logic [IW-1:0] rank_q [N];
  logic [DW-1:0] smp_d  [N];
  logic [IW-1:0] rank_d [N];
  logic [PW-1:0] pos_q;
  logic [N-1:0]  lt, hit;
  logic [DW-1:0] sel_val;
  logic [IW-1:0] sel_idx;

  wire take = in_valid && (pos_q < PW'(N));
  wire done = in_valid && in_last;

  always_comb begin
    for (int j = 0; j < N; j++)
      lt[j] = take && (PW'(j) < pos_q) && (in_data < smp_q[j]);
    sel_val = '0;
    sel_idx = '0;
    for (int j = 0; j < N; j++) begin
      smp_d[j]  = smp_q[j];
      rank_d[j] = rank_q[j] + IW'(lt[j]);
      if (take && pos_q == PW'(j)) begin
        smp_d[j]  = in_data;
        rank_d[j] = IW'(j) - IW'($countones(lt));
      end
      hit[j] = (rank_d[j] == IW'(MID));
      if (hit[j]) begin
        sel_val = sel_val | smp_d[j];
        sel_idx = sel_idx | IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q      <= '0;
      out_valid  <= 1'b0;
      out_median <= '0;
      out_index  <= '0;
      for (int j = 0; j < N; j++) begin
        smp_q[j]  <= '0;
        rank_q[j] <= '0;
      end
    end else begin
      smp_q     <= smp_d;
      rank_q    <= rank_d;
      out_valid <= done;
      if (done) begin
        pos_q      <= '0;
        out_median <= sel_val;
        out_index  <= sel_idx;
      end else if (take) begin
        pos_q <= pos_q + 1'b1;
      end
    end
  end

  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pos_q == PW'(N - 1)) |-> ($countones(hit) == 1));

  p_index_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_index < IW'(N)));

  p_strobe_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(done));

  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(out_median) && $stable(out_index)));

  p_idle_no_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(pos_q));

  p_full_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last && pos_q == PW'(N)) |=> (pos_q == PW'(N)));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (pos_q == '0));

endmodule

// File: tb/median_rank_select_bench.sv
module median_rank_select_bench;
  localparam int N = 5;
  localparam int DW = 8;
  localparam int IW = $clog2(N);
  localparam int MID = (N - 1) / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid;
  logic [DW-1:0] out_median;
  logic [IW-1:0] out_index;

  int checks = 0;
  int errors = 0;
  int vals [8];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  median_rank_select #(.N(N), .DW(DW)) u_median_rank_select (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_data(in_data), .out_valid(out_valid), .out_median(out_median),
    .out_index(out_index)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_index();
    for (int i = 0; i < N; i++) begin
      int r = 0;
      for (int j = 0; j < N; j++) begin
        if (vals[j] < vals[i]) r++;
        if (j < i && vals[j] == vals[i]) r++;
      end
      if (r == MID) return i;
    end
    return -1;
  endfunction

  task automatic run_window(input int nv, input bit gaps, input string req);
    int ei;
    for (int i = 0; i < nv; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = DW'(vals[i]);
      in_last  = (i == nv - 1);
      if (i != nv - 1 && !in_last) begin
        if (gaps) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_last  = 1'b1;
          in_data  = 8'hEE;
          chk(out_valid == 1'b0, "R7", out_valid, 0);
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    ei = exp_index();
    chk(out_valid == 1'b1, "R5", out_valid, 1);
    chk(out_index == IW'(ei), {req, "/R4 index"}, out_index, ei);
    chk(out_median == DW'(vals[ei]), {req, "/R4 value"}, out_median, vals[ei]);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 pulse", out_valid, 0);
    chk(out_median == DW'(vals[ei]) && out_index == IW'(ei), "R6", out_median, vals[ei]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_median == 0 && out_index == 0, "R1 in reset", out_median, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_median == 0 && out_index == 0, "R1 after reset", out_median, 0);

    // R10 worked example
    vals[0] = 20; vals[1] = 42; vals[2] = 31; vals[3] = 16; vals[4] = 75;
    run_window(5, 1'b0, "R10");
    chk(out_median == 8'd31 && out_index == 2, "R10", out_median, 31);

    // R3 all equal: rank follows arrival, middle position wins
    for (int i = 0; i < N; i++) vals[i] = 9;
    run_window(5, 1'b0, "R3");
    chk(out_index == IW'(MID), "R3 ties", out_index, MID);

    // R7 idle cycles with stray last flag
    vals[0] = 200; vals[1] = 3; vals[2] = 77; vals[3] = 150; vals[4] = 1;
    run_window(5, 1'b1, "R7");

    // R8 extra samples after the N-th are dropped
    vals[0] = 10; vals[1] = 50; vals[2] = 30; vals[3] = 40; vals[4] = 20;
    vals[5] = 0; vals[6] = 255;
    run_window(7, 1'b0, "R8");
    chk(out_median == 8'd30 && out_index == 2, "R8", out_median, 30);

    // R2 R3 R9 exhaustive sweep over values 0..4, windows back to back
    for (int w = 0; w < 3125; w++) begin
      int t = w;
      for (int i = 0; i < N; i++) begin
        vals[i] = t % 5;
        t = t / 5;
      end
      run_window(5, (w % 97) == 0, "R2/R3/R9");
    end

    // R2 wide-range distinct-ish data
    for (int w = 0; w < 200; w++) begin
      for (int i = 0; i < N; i++) vals[i] = (w * 37 + i * 91 + i * i * w) % 256;
      run_window(5, 1'b0, "R2");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule